// File: doc/BRIEF.md
# Multiply-Step Execution Unit

This unit carries out one shift-and-add step of an unsigned shift-add multiplication each time an operation is issued. Each step shifts the first operand right by one. The vacated top bit is filled with the exclusive-OR of the incoming negative and overflow flags. The low bit of an internal Y register decides whether the second operand or zero is added to that shifted value. The step produces a new result and a fresh set of negative, zero, overflow and carry flags. Y shifts right at the same time and takes in the bit that the first operand lost.

A small sequencer inside the unit can run a whole multiplication. Software first loads the multiplier into Y through a direct write port. It then pulses a start strobe together with the multiplicand. The sequencer clears the accumulator and flags, issues one step per clock with the accumulator fed back as the first operand, and raises a one-cycle done pulse when it finishes.

Top module: `mulstep_unit`

## Requirements
- R1: A step builds its shifted operand as {N xor V, op1[W-1:1]}. N and V are the flag values presented for that step: the inputs for an external step, the registered flags during a sequence.
- R2: The addend is op2 when Y bit 0 is 1 and zero when Y bit 0 is 0.
- R3: After a step, the result output equals shifted operand plus addend, modulo 2^W.
- R4: After a step, Y equals {op1[0], Y[W-1:1]}, where op1[0] is the low bit of the unshifted first operand.
- R5: After a step, Z is 1 exactly when the result is zero, and N equals result bit W-1.
- R6: After a step, C is 1 exactly when the unsigned addition carried out of bit W-1, that is when the result is below the shifted operand.
- R7: After a step, V is 1 exactly when shifted operand and addend share a sign bit and the result's sign bit differs from it.
- R8: Result, flags and Y change only on a step, on a sequence start or (Y only) on a Y write. A Y write in the same cycle as an external step is dropped, and the step's Y update wins.
- R9: A synchronous active-high reset clears result, Y, all four flags, the sequencer and the done output.
- R10: An accepted start clears result and all flags and captures the multiplicand. Exactly W steps follow on the next W clocks, and done is high for one cycle starting right after the last step.
- R11: After a full run that starts from Y = multiplier, {result[0], Y[W-1:1]} equals the low W bits of multiplier times multiplicand.
- R12: While a sequence runs, external step strobes, Y writes and further start strobes have no effect on the outcome.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| step_valid | input | 1 | Issue one external step this cycle |
| step_op1 | input | W | First operand of an external step |
| step_op2 | input | W | Second operand of an external step |
| flag_n_in | input | 1 | Negative flag fed to an external step |
| flag_v_in | input | 1 | Overflow flag fed to an external step |
| y_wr_en | input | 1 | Load Y directly |
| y_wr_data | input | W | Value loaded into Y |
| seq_start | input | 1 | Begin a W-step multiplication |
| seq_multiplicand | input | W | Multiplicand captured at start |
| result | output | W | Result of the latest step |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_v | output | 1 | Overflow flag |
| flag_c | output | 1 | Carry flag |
| y_out | output | W | Current Y register |
| seq_done | output | 1 | One-cycle pulse after the last sequenced step |

## Verification
The bench builds the unit with W = 8. At that width every first operand can be swept against a set of edge-case second operands, both Y low-bit values and all four N/V combinations, each step compared with an arithmetic model. The narrow width also makes full multiplications cheap. Every multiplier value is run against a spread of multiplicands, so the product check covers the whole multiplier range, including runs disturbed by stray strobes and a reset during a run.

// File: rtl/mulstep_pkg.sv
package mulstep_pkg;

    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
    } flags_t;

endpackage

// File: rtl/mulstep_datapath.sv
module mulstep_datapath #(
    parameter int W = 32
) (
    input  logic                  [W-1:0] op1,
    input  logic                  [W-1:0] op2,
    input  logic                  [W-1:0] y_cur,
    input  logic                          n_in,
    input  logic                          v_in,
    output logic                  [W-1:0] sum,
    output logic                  [W-1:0] y_nxt,
    output mulstep_pkg::flags_t           flg
);
    localparam int MSB = W - 1;

    logic [W-1:0] shifted;
    logic [W-1:0] addend;

    always_comb begin
        // vacated top bit takes the sign of the previous true sum
        shifted = {n_in ^ v_in, op1[MSB:1]};
        addend  = y_cur[0] ? op2 : '0;
        sum     = shifted + addend;
        y_nxt   = {op1[0], y_cur[MSB:1]};
        flg     = '0;
        flg.n   = sum[MSB];
        flg.z   = (sum == '0);
        flg.c   = (sum < shifted);
        flg.v   = (shifted[MSB] == addend[MSB]) && (sum[MSB] != shifted[MSB]);
    end
endmodule

// File: rtl/mulstep_sequencer.sv
module mulstep_sequencer #(
    parameter int W = 32
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic start_ok,
    output logic run,
    output logic done
);
    localparam int CNT_W = (W > 2) ? $clog2(W) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(W - 1);

    typedef struct packed {
        logic             run;
        logic             done;
        logic [CNT_W-1:0] cnt;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d      = seq_q;
        seq_d.done = 1'b0;
        start_ok   = start && !seq_q.run;
        if (start_ok) begin
            seq_d.run = 1'b1;
            seq_d.cnt = '0;
        end else if (seq_q.run) begin
            seq_d.cnt = seq_q.cnt + 1'b1;
            if (seq_q.cnt == LAST) begin
                seq_d.run  = 1'b0;
                seq_d.done = 1'b1;
                seq_d.cnt  = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) seq_q <= '0;
        else     seq_q <= seq_d;
    end

    assign run  = seq_q.run;
    assign done = seq_q.done;

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        seq_q.done |=> !seq_q.done);
    assert_done_after_run_R10: assert property (@(posedge clk) disable iff (rst)
        (seq_q.run && !seq_d.run) |=> seq_q.done);
    assert_no_restart_R12: assert property (@(posedge clk) disable iff (rst)
        (seq_q.run && start && seq_q.cnt != LAST) |=> (seq_q.run && seq_q.cnt == $past(seq_q.cnt) + 1'b1));
endmodule

// File: rtl/mulstep_unit.sv
module mulstep_unit #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         step_valid,
    input  logic [W-1:0] step_op1,
    input  logic [W-1:0] step_op2,
    input  logic         flag_n_in,
    input  logic         flag_v_in,
    input  logic         y_wr_en,
    input  logic [W-1:0] y_wr_data,
    input  logic         seq_start,
    input  logic [W-1:0] seq_multiplicand,
    output logic [W-1:0] result,
    output logic         flag_n,
    output logic         flag_z,
    output logic         flag_v,
    output logic         flag_c,
    output logic [W-1:0] y_out,
    output logic         seq_done
);
    typedef struct packed {
        logic [W-1:0]        acc;
        logic [W-1:0]        y;
        mulstep_pkg::flags_t flg;
        logic [W-1:0]        mcand;
    } unit_t;

    unit_t st_d, st_q;

    logic                run, start_ok, ext_fire, step_fire;
    logic [W-1:0]        op1_sel, op2_sel, sum, y_nxt;
    logic                n_sel, v_sel;
    mulstep_pkg::flags_t new_flg;

    mulstep_sequencer #(.W(W)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .start    (seq_start),
        .start_ok (start_ok),
        .run      (run),
        .done     (seq_done)
    );

    always_comb begin
        ext_fire  = step_valid && !run && !start_ok;
        step_fire = run || ext_fire;
        op1_sel   = run ? st_q.acc   : step_op1;
        op2_sel   = run ? st_q.mcand : step_op2;
        n_sel     = run ? st_q.flg.n : flag_n_in;
        v_sel     = run ? st_q.flg.v : flag_v_in;
    end

    mulstep_datapath #(.W(W)) u_dp (
        .op1   (op1_sel),
        .op2   (op2_sel),
        .y_cur (st_q.y),
        .n_in  (n_sel),
        .v_in  (v_sel),
        .sum   (sum),
        .y_nxt (y_nxt),
        .flg   (new_flg)
    );

    always_comb begin
        st_d = st_q;
        if (start_ok) begin
            st_d.acc   = '0;
            st_d.flg   = '0;
            st_d.mcand = seq_multiplicand;
        end else if (step_fire) begin
            st_d.acc = sum;
            st_d.flg = new_flg;
            st_d.y   = y_nxt;
        end else if (y_wr_en && !run) begin
            st_d.y = y_wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign result = st_q.acc;
    assign flag_n = st_q.flg.n;
    assign flag_z = st_q.flg.z;
    assign flag_v = st_q.flg.v;
    assign flag_c = st_q.flg.c;
    assign y_out  = st_q.y;

    assert_y_shift_R4: assert property (@(posedge clk) disable iff (rst)
        (step_fire && !start_ok) |=> (st_q.y[W-2:0] == $past(st_q.y[W-1:1])));
    assert_zero_addend_R2: assert property (@(posedge clk) disable iff (rst)
        (ext_fire && !st_q.y[0]) |=> (result == {$past(flag_n_in ^ flag_v_in), $past(step_op1[W-1:1])}));
    assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (!step_fire && !start_ok && !y_wr_en) |=> ($stable(result) && $stable(y_out) && $stable(st_q.flg)));
    assert_start_clear_R10: assert property (@(posedge clk) disable iff (rst)
        start_ok |=> (result == '0 && !flag_n && !flag_v && !flag_z && !flag_c));
    assert_y_ignored_in_run_R12: assert property (@(posedge clk) disable iff (rst)
        (run && y_wr_en) |=> (y_out[W-2:0] == $past(y_out[W-1:1])));
endmodule

// File: tb/mulstep_unit_tb.sv
module mulstep_unit_tb;
    localparam int DW = 8;
    localparam int CLK_PERIOD = 10;
    localparam int WD_LIMIT = 150000;
    localparam int MASK = (1 << DW) - 1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          step_valid = 1'b0;
    logic [DW-1:0] step_op1 = '0, step_op2 = '0;
    logic          flag_n_in = 1'b0, flag_v_in = 1'b0;
    logic          y_wr_en = 1'b0;
    logic [DW-1:0] y_wr_data = '0;
    logic          seq_start = 1'b0;
    logic [DW-1:0] seq_multiplicand = '0;
    logic [DW-1:0] result, y_out;
    logic          flag_n, flag_z, flag_v, flag_c, seq_done;

    int n_cmp = 0, n_bad = 0, cycles = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mulstep_unit #(.W(DW)) u_dut (
        .clk(clk), .rst(rst), .step_valid(step_valid), .step_op1(step_op1),
        .step_op2(step_op2), .flag_n_in(flag_n_in), .flag_v_in(flag_v_in),
        .y_wr_en(y_wr_en), .y_wr_data(y_wr_data), .seq_start(seq_start),
        .seq_multiplicand(seq_multiplicand), .result(result), .flag_n(flag_n),
        .flag_z(flag_z), .flag_v(flag_v), .flag_c(flag_c), .y_out(y_out),
        .seq_done(seq_done)
    );

    task automatic check(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    task automatic write_y(input int val);
        @(negedge clk);
        y_wr_en = 1'b1; y_wr_data = DW'(val);
        @(negedge clk);
        y_wr_en = 1'b0;
    endtask

    // arithmetic model of one step; returns {y, c, v, z, n, res}
    task automatic model(input int a, input int b, input int y, input int n, input int v,
                         output int res, output int fn, output int fz, output int fv,
                         output int fc, output int ny);
        int sh, ad, full, ssh, sad, ssum;
        sh   = ((n ^ v) * (1 << (DW-1))) + (a / 2);
        ad   = (y % 2 == 1) ? b : 0;
        full = sh + ad;
        res  = full % (1 << DW);
        fc   = (full > MASK) ? 1 : 0;
        fz   = (res == 0) ? 1 : 0;
        fn   = (res >= (1 << (DW-1))) ? 1 : 0;
        ssh  = (sh  >= (1 << (DW-1))) ? sh - (1 << DW) : sh;
        sad  = (ad  >= (1 << (DW-1))) ? ad - (1 << DW) : ad;
        ssum = ssh + sad;
        fv   = (ssum > (1 << (DW-1)) - 1 || ssum < -(1 << (DW-1))) ? 1 : 0;
        ny   = (a % 2) * (1 << (DW-1)) + (y / 2);
    endtask

    task automatic one_step(input int a, input int b, input int y, input int n, input int v);
        int er, en, ez, ev, ec, ey;
        write_y(y);
        @(negedge clk);
        step_valid = 1'b1; step_op1 = DW'(a); step_op2 = DW'(b);
        flag_n_in = n[0]; flag_v_in = v[0];
        @(negedge clk);
        step_valid = 1'b0;
        model(a, b, y, n, v, er, en, ez, ev, ec, ey);
        check("R1 R2 R3 result", int'(result), er);
        check("R4 y", int'(y_out), ey);
        check("R5 n/z", int'({flag_n, flag_z}), en * 2 + ez);
        check("R6 c", int'(flag_c), ec);
        check("R7 v", int'(flag_v), ev);
    endtask

    task automatic start_seq(input int mc);
        @(negedge clk);
        seq_start = 1'b1; seq_multiplicand = DW'(mc);
        @(negedge clk);
        seq_start = 1'b0;
    endtask

    task automatic run_mul(input int a, input int b, input bit disturb);
        int waited;
        write_y(a);
        start_seq(b);
        check("R10 start clears", int'({result, flag_n, flag_z, flag_v, flag_c}), 0);
        if (disturb) begin
            // R12: stray strobes while running
            step_valid = 1'b1; step_op1 = '1; step_op2 = '1;
            y_wr_en = 1'b1; y_wr_data = 8'h5A; seq_start = 1'b1; seq_multiplicand = '1;
            repeat (3) @(negedge clk);
            step_valid = 1'b0; y_wr_en = 1'b0; seq_start = 1'b0;
            waited = 3;
        end else waited = 0;
        while (!seq_done) begin
            @(negedge clk);
            waited++;
        end
        check("R10 done timing", waited, DW);
        check(disturb ? "R12 product under strobes" : "R11 product",
              int'({result[0], y_out[DW-1:1]}), (a * b) % (1 << DW));
        @(negedge clk);
        check("R10 done one cycle", int'(seq_done), 0);
    endtask

    initial begin
        int bvals[6] = '{0, 1, 8'h7F, 8'h80, 8'hFF, 8'h55};
        int mvals[7] = '{0, 1, 3, 8'h80, 8'hFF, 8'hA5, 8'h7F};
        int er, en, ez, ev, ec, ey;
        repeat (3) @(negedge clk);
        check("R9 reset state", int'({result, y_out, flag_n, flag_z, flag_v, flag_c, seq_done}), 0);
        rst = 1'b0;

        // single-step sweep
        for (int a = 0; a < (1 << DW); a++)
            for (int bi = 0; bi < 6; bi++)
                for (int nv = 0; nv < 4; nv++)
                    one_step(a, bvals[bi], ((a * 3 + bvals[bi]) & 8'hFE) | ((a + nv) & 1),
                             nv / 2, nv % 2);

        // R8: idle cycles leave everything unchanged
        one_step(8'hC3, 8'h3C, 8'h81, 1, 0);
        er = int'({result, y_out, flag_n, flag_z, flag_v, flag_c});
        repeat (4) @(negedge clk);
        check("R8 idle hold", int'({result, y_out, flag_n, flag_z, flag_v, flag_c}), er);

        // R8: step and Y write together, step wins
        write_y(8'h33);
        @(negedge clk);
        step_valid = 1'b1; step_op1 = 8'h02; step_op2 = 8'h10;
        flag_n_in = 1'b0; flag_v_in = 1'b0;
        y_wr_en = 1'b1; y_wr_data = 8'hEE;
        @(negedge clk);
        step_valid = 1'b0; y_wr_en = 1'b0;
        model(2, 8'h10, 8'h33, 0, 0, er, en, ez, ev, ec, ey);
        check("R8 step beats write y", int'(y_out), ey);
        check("R8 step beats write result", int'(result), er);

        // full multiplications
        for (int mi = 0; mi < 7; mi++)
            for (int a = 0; a < (1 << DW); a++)
                run_mul(a, mvals[mi], 1'b0);
        run_mul(8'hB7, 8'hD9, 1'b1);
        run_mul(8'hFF, 8'hFF, 1'b1);

        // R9: reset during a run
        write_y(8'h9C);
        start_seq(8'h6B);
        repeat (3) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R9 mid-run reset", int'({result, y_out, flag_n, flag_z, flag_v, flag_c, seq_done}), 0);
        repeat (DW + 2) @(negedge clk);
        check("R9 no done after reset", int'({seq_done, result}), 0);
        run_mul(8'h9C, 8'h6B, 1'b0);

        finish_run();
    end

    initial begin
        while (cycles < WD_LIMIT) begin
            @(posedge clk);
            cycles++;
        end
        n_cmp++; n_bad++;
        $display("FAIL watchdog actual=%0d expected=<%0d cycles", cycles, WD_LIMIT);
        finish_run();
    end
endmodule